// File: doc/BRIEF.md
# Network controller interrupt flag unit

This block gathers three interrupt sources of a small Ethernet-style controller into one active-low interrupt pin. The sources are a link-change event, which passes through a small PHY-side interrupt stage with its own two enable bits, a DMA-done event taken from the falling edge of the DMA busy bit, and a receive-packet-pending condition taken from the received-packet counter. Each flag has its own way of clearing. The link flag clears when the host reads the PHY interrupt register, which arrives here as a one-cycle strobe. The DMA flag clears through a host bit-clear write. The packet flag clears only when the counter reaches zero.

A simple host register port gives access to the flags, the source enables, the global enable, the PHY-side enables and the PHY-side flags. The flags keep updating while their enables are off, so the host can poll them. The enables only gate the pin. The pin is registered and stays high during reset. The reset input is asynchronous and is released on the clock.

Top module: `netc_irq_unit`

## Requirements
- R1: The controller link flag (address 0, bit 2) stays 0 from reset until both PHY enables are 1. These are address 2 bit 0 (link-change enable) and address 2 bit 1 (PHY global enable). It also stays 0 in any cycle after a cycle in which either PHY enable is 0.
- R2: A one-cycle link_chg pulse latches the PHY link-change flag (address 3 bit 0) whatever the enables are. The PHY global flag (address 3 bit 1) equals the link-change flag ANDed with both PHY enables. The controller link flag mirrors the PHY global flag.
- R3: A phy_irq_rd strobe clears the PHY link-change flag, the PHY global flag and the controller link flag together, and later pulses set them again. If a pulse and the strobe fall in the same cycle, the flags end up set.
- R4: A write to address 0 clears only the DMA flag. Writing 1 to bit 0 or bit 2 leaves the packet flag and the link flag unchanged.
- R5: A 1-to-0 change of dma_busy sets the DMA flag (address 0 bit 1) on the next clock edge. This covers a normal completion and a cancel alike. A 0-to-1 change sets nothing.
- R6: The DMA flag stays set until a write to address 0 with bit 1 high. If a falling edge of busy arrives in the same cycle as that write, the flag stays set.
- R7: The packet flag (address 0 bit 0) is 1 exactly when the pkt_count of the previous cycle was non-zero.
- R8: irq_n goes low one cycle after any flag is 1 while its own enable is 1 (address 1, in the same bit position as the flag) and the global enable (address 1 bit 7) is 1.
- R9: The flags update and can be read whatever the enable bits are. Addresses 1 and 2 read back the full byte last written to them.
- R10: Reset clears all flags and enables and holds irq_n high. irq_n returns high one cycle after the last enabled flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr (combinational) |
| phy_irq_rd | input | 1 | One-cycle strobe: the host read the PHY interrupt register |
| link_chg | input | 1 | One-cycle link status change pulse |
| dma_busy | input | 1 | DMA busy bit |
| pkt_count | input | PKT_CNT_W | Received-packet counter |
| irq_n | output | 1 | Active-low interrupt pin, registered |

## Verification
A wrong PHY-side latch shows at address 3 in the cycle after the pulse or the strobe. A broken mirror shows up as a mismatch between address 3 bit 1 and address 0 bit 2. A stuck or missing DMA or packet flag shows at address 0 one edge after its cause. A wrong enable gate or a bad pin register shows on irq_n one edge later, so the sweep over every flag pattern and every enable pattern catches any gating error within two cycles of the stimulus.

// File: rtl/netc_irq_pkg.sv
package netc_irq_pkg;
  localparam int DW      = 8;
  localparam int NUM_SRC = 3;
  localparam int BIT_PKT = 0;
  localparam int BIT_DMA = 1;
  localparam int BIT_LINK = 2;
  localparam int BIT_GIE = 7;
  localparam int BIT_PHY_LNK = 0;
  localparam int BIT_PHY_GLB = 1;

  typedef enum logic [1:0] {
    REG_FLAGS    = 2'd0,
    REG_ENABLE   = 2'd1,
    REG_PHY_EN   = 2'd2,
    REG_PHY_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/netc_rst_sync.sv
module netc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/netc_phy_link_irq.sv
module netc_phy_link_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic link_chg_i,
  input  logic phy_rd_i,
  input  logic en_link_i,
  input  logic en_glob_i,
  output logic plnk_o,
  output logic pgif_o
);
  logic plnk_q, plnk_d;
  logic pgif_q, pgif_d;

  // the set term wins over the clearing read
  always_comb begin
    plnk_d = link_chg_i | (plnk_q & ~phy_rd_i);
    pgif_d = plnk_d & en_link_i & en_glob_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plnk_q <= 1'b0;
      pgif_q <= 1'b0;
    end else begin
      plnk_q <= plnk_d;
      pgif_q <= pgif_d;
    end
  end

  assign plnk_o = plnk_q;
  assign pgif_o = pgif_q;
endmodule

// File: rtl/netc_dma_done.sv
module netc_dma_done (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic clr_i,
  output logic flag_o,
  output logic prev_o
);
  logic prev_q, prev_d;
  logic flag_q, flag_d;
  logic fall;

  always_comb begin
    fall   = prev_q & ~busy_i;
    prev_d = busy_i;
    flag_d = fall | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/netc_irq_regs.sv
module netc_irq_regs
  import netc_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [1:0]         host_addr,
  input  logic [DW-1:0]      host_wdata,
  input  logic [NUM_SRC-1:0] flags_i,
  input  logic               plnk_i,
  input  logic               pgif_i,
  output logic [DW-1:0]      host_rdata,
  output logic [NUM_SRC-1:0] src_en_o,
  output logic               gie_o,
  output logic               phy_en_link_o,
  output logic               phy_en_glob_o,
  output logic               dma_clr_o,
  output logic               irq_n_o
);
  logic [DW-1:0] en_q, en_d;
  logic [DW-1:0] phy_q, phy_d;
  logic          irq_n_q, irq_n_d;
  logic          wr_en, wr_phy;

  always_comb begin
    wr_en     = host_wr && (host_addr == REG_ENABLE);
    wr_phy    = host_wr && (host_addr == REG_PHY_EN);
    dma_clr_o = host_wr && (host_addr == REG_FLAGS) && host_wdata[BIT_DMA];
    en_d      = wr_en  ? host_wdata : en_q;
    phy_d     = wr_phy ? host_wdata : phy_q;
    irq_n_d   = ~((|(flags_i & en_q[NUM_SRC-1:0])) & en_q[BIT_GIE]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      phy_q   <= '0;
      irq_n_q <= 1'b1;
    end else begin
      en_q    <= en_d;
      phy_q   <= phy_d;
      irq_n_q <= irq_n_d;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      REG_FLAGS:    host_rdata[NUM_SRC-1:0] = flags_i;
      REG_ENABLE:   host_rdata = en_q;
      REG_PHY_EN:   host_rdata = phy_q;
      default: begin
        host_rdata[BIT_PHY_LNK] = plnk_i;
        host_rdata[BIT_PHY_GLB] = pgif_i;
      end
    endcase
  end

  assign src_en_o      = en_q[NUM_SRC-1:0];
  assign gie_o         = en_q[BIT_GIE];
  assign phy_en_link_o = phy_q[BIT_PHY_LNK];
  assign phy_en_glob_o = phy_q[BIT_PHY_GLB];
  assign irq_n_o       = irq_n_q;
endmodule

// File: rtl/netc_irq_unit.sv
module netc_irq_unit
  import netc_irq_pkg::*;
#(
  parameter int PKT_CNT_W   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr,
  input  logic [1:0]           host_addr,
  input  logic [DW-1:0]        host_wdata,
  output logic [DW-1:0]        host_rdata,
  input  logic                 phy_irq_rd,
  input  logic                 link_chg,
  input  logic                 dma_busy,
  input  logic [PKT_CNT_W-1:0] pkt_count,
  output logic                 irq_n
);
  logic               rst_n_sync;
  logic               plnk, pgif;
  logic               dma_flag, dma_prev, dma_clr;
  logic               pkt_q, pkt_d;
  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] src_en;
  logic               gie, phy_en_link, phy_en_glob;

  netc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_sync)
  );

  netc_phy_link_irq u_phy (
    .clk(clk), .rst_n(rst_n_sync), .link_chg_i(link_chg), .phy_rd_i(phy_irq_rd),
    .en_link_i(phy_en_link), .en_glob_i(phy_en_glob), .plnk_o(plnk), .pgif_o(pgif)
  );

  netc_dma_done u_dma (
    .clk(clk), .rst_n(rst_n_sync), .busy_i(dma_busy), .clr_i(dma_clr),
    .flag_o(dma_flag), .prev_o(dma_prev)
  );

  always_comb begin
    pkt_d = |pkt_count;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) pkt_q <= 1'b0;
    else             pkt_q <= pkt_d;
  end

  always_comb begin
    flags           = '0;
    flags[BIT_PKT]  = pkt_q;
    flags[BIT_DMA]  = dma_flag;
    flags[BIT_LINK] = pgif;
  end

  netc_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n_sync), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .flags_i(flags), .plnk_i(plnk), .pgif_i(pgif),
    .host_rdata(host_rdata), .src_en_o(src_en), .gie_o(gie),
    .phy_en_link_o(phy_en_link), .phy_en_glob_o(phy_en_glob),
    .dma_clr_o(dma_clr), .irq_n_o(irq_n)
  );
endmodule

// File: rtl/netc_irq_chk.sv
module netc_irq_chk
  import netc_irq_pkg::*;
#(
  parameter int PKT_CNT_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 link_chg,
  input logic                 phy_rd,
  input logic                 en_link,
  input logic                 en_glob,
  input logic                 plnk,
  input logic                 pgif,
  input logic                 dma_busy,
  input logic                 dma_prev,
  input logic                 dma_clr,
  input logic                 dma_flag,
  input logic [PKT_CNT_W-1:0] pkt_count,
  input logic                 pkt_flag,
  input logic [NUM_SRC-1:0]   flags,
  input logic [NUM_SRC-1:0]   src_en,
  input logic                 gie,
  input logic                 irq_n
);
  assert_link_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_link && en_glob) |=> !pgif);
  assert_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pgif |-> plnk);
  assert_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    link_chg |=> plnk);
  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_rd && !link_chg) |=> (!plnk && !pgif));
  assert_dma_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_prev && !dma_busy) |=> dma_flag);
  assert_dma_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_flag && !dma_clr) |=> dma_flag);
  assert_pkt_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_count != '0) |=> pkt_flag);
  assert_pkt_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_count == '0) |=> !pkt_flag);
  assert_pin_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(flags & src_en)) && gie) |=> !irq_n);
  assert_pin_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !((|(flags & src_en)) && gie) |=> irq_n);
endmodule

bind netc_irq_unit netc_irq_chk #(.PKT_CNT_W(PKT_CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .link_chg(link_chg), .phy_rd(phy_irq_rd),
  .en_link(phy_en_link), .en_glob(phy_en_glob), .plnk(plnk), .pgif(pgif),
  .dma_busy(dma_busy), .dma_prev(dma_prev), .dma_clr(dma_clr), .dma_flag(dma_flag),
  .pkt_count(pkt_count), .pkt_flag(pkt_q), .flags(flags), .src_en(src_en),
  .gie(gie), .irq_n(irq_n)
);

// File: tb/netc_irq_unit_bench.sv
module netc_irq_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       phy_irq_rd = 1'b0;
  logic       link_chg = 1'b0;
  logic       dma_busy = 1'b0;
  logic [7:0] pkt_count = 8'd0;
  logic       irq_n;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  netc_irq_unit u_netc_irq_unit (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .phy_irq_rd(phy_irq_rd),
    .link_chg(link_chg), .dma_busy(dma_busy), .pkt_count(pkt_count), .irq_n(irq_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    tick(1);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic pulse_link();
    link_chg = 1'b1; tick(1); link_chg = 1'b0;
  endtask

  task automatic pulse_phyrd();
    phy_irq_rd = 1'b1; tick(1); phy_irq_rd = 1'b0;
  endtask

  task automatic dma_fall();
    dma_busy = 1'b1; tick(1); dma_busy = 1'b0; tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    tick(3);
    chk("R10 pin high in reset", irq_n, 1);
    rst_n = 1'b1;
    tick(4);
    rd(2'd0, v); chk("R10 flags after reset", v, 0);
    rd(2'd1, v); chk("R10 enables after reset", v, 0);
    chk("R10 pin after reset", irq_n, 1);

    // R1 / R2: link pulse with PHY enables off
    pulse_link();
    rd(2'd3, v); chk("R2 phy link latched, global clear", v, 8'h01);
    rd(2'd0, v); chk("R1 link flag gated", v, 0);
    wr(2'd2, 8'h01); tick(1);
    rd(2'd0, v); chk("R1 link gated, one enable", v, 0);
    wr(2'd2, 8'h02); tick(1);
    rd(2'd0, v); chk("R1 link gated, other enable", v, 0);
    wr(2'd2, 8'h03); tick(1);
    rd(2'd0, v); chk("R2 link mirrors global", v, 8'h04);
    rd(2'd3, v); chk("R2 phy status both", v, 8'h03);
    rd(2'd2, v); chk("R9 phy enable readback", v, 8'h03);

    // R4: bit-clear does not touch the link flag
    wr(2'd0, 8'h07);
    rd(2'd0, v); chk("R4 link survives bit-clear", v, 8'h04);
    // R3
    pulse_phyrd();
    rd(2'd3, v); chk("R3 phy flags cleared", v, 0);
    rd(2'd0, v); chk("R3 link flag cleared", v, 0);
    pulse_link();
    rd(2'd0, v); chk("R3 re-armed", v, 8'h04);
    link_chg = 1'b1; phy_irq_rd = 1'b1; tick(1); link_chg = 1'b0; phy_irq_rd = 1'b0;
    rd(2'd3, v); chk("R3 set wins over read", v, 8'h03);
    pulse_phyrd();

    // R5 / R6
    dma_busy = 1'b1; tick(2);
    rd(2'd0, v); chk("R5 rising busy no flag", v, 0);
    dma_busy = 1'b0; tick(1);
    rd(2'd0, v); chk("R5 falling busy sets", v, 8'h02);
    tick(5);
    rd(2'd0, v); chk("R6 dma holds", v, 8'h02);
    wr(2'd0, 8'h02);
    rd(2'd0, v); chk("R6 bit-clear clears dma", v, 0);
    dma_busy = 1'b1; tick(1);
    dma_busy = 1'b0; host_wr = 1'b1; host_addr = 2'd0; host_wdata = 8'h02;
    tick(1); host_wr = 1'b0;
    rd(2'd0, v); chk("R6 edge wins over clear", v, 8'h02);
    wr(2'd0, 8'h02);

    // R4 / R7: packet flag
    pkt_count = 8'd1; tick(1);
    wr(2'd0, 8'h01);
    rd(2'd0, v); chk("R4 pkt survives bit-clear", v, 8'h01);
    for (int c = 0; c < 256; c++) begin
      pkt_count = 8'(c); tick(1);
      rd(2'd0, v); chk("R7 pkt flag vs count", v, (c != 0) ? 1 : 0);
    end
    pkt_count = 8'd0; tick(1);

    // R8 / R9: every flag pattern against every enable pattern
    for (int f = 0; f < 8; f++) begin
      for (int e = 0; e < 16; e++) begin
        pkt_count = f[0] ? 8'd5 : 8'd0;
        pulse_phyrd();
        wr(2'd0, 8'h02);
        if (f[1]) dma_fall();
        if (f[2]) pulse_link();
        wr(2'd1, {e[3], 4'b0000, e[2:0]});
        tick(1);
        rd(2'd0, v); chk("R9 flags independent of enables", v, f);
        chk("R8 pin gating", irq_n, ((f & e & 7) != 0 && e[3]) ? 0 : 1);
      end
    end
    rd(2'd1, v); chk("R9 enable readback", v, 8'h87);

    // R10: pin returns high one cycle after the last enabled flag clears
    pkt_count = 8'd0; pulse_phyrd(); tick(2);
    wr(2'd0, 8'h02);
    chk("R10 pin still low", irq_n, 0);
    tick(1);
    chk("R10 pin released", irq_n, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule